// File: doc/BRIEF.md
# Return-from-Exception Frame Checker

This block sits beside the exception sequencer and judges a stack frame that has just been read back by a return-from-exception instruction. It is given the frame's format code, the status register and program counter held in the frame, and three pending-exception flags that an access-fault frame can carry. From these it picks one outcome. The context can be restored as stacked. The frame can be rewritten into the frame of an exception that is still pending, with that exception's vector. Or a new exception is raised, either an address error for an odd return address under user tracing, or a format error for a frame code it does not recognise.

For every outcome it supplies the format code of the frame that the sequencer should write or restore, the vector number, the status register value to stack or reload, and how many long-word transfers the incoming frame occupies. The frame fields feed pure logic, followed by one register stage. The result strobe follows the input strobe by exactly one clock.

Top module: `rte_frame_check`

## Requirements
- R1: While reset is high and on the first clock after it, `res_valid` is 0, `res_action` is 0 (restore), `res_vector` is 0, `res_fmt` is 0 and `res_sr` is 0.
- R2: `res_valid` is high exactly on the clock after each clock with `frm_valid` high. When `frm_valid` is low, all result outputs hold their previous values.
- R3: A format code other than 0, 2, 3, 4 or 7 gives action 3 (format error), vector 14, `res_fmt` 0, `res_longs` 0, and `res_sr` equal to the frame SR. This applies whatever the pending flags and PC are.
- R4: Format 7 with `frm_pend[1]` set (floating-point post-instruction) gives action 1 (redirect), `res_fmt` 3, vector 54 and `res_sr` equal to the frame SR.
- R5: Format 7 with `frm_pend[2]` set (unimplemented floating-point) and `frm_pend[1]` clear gives action 1, `res_fmt` 2, vector 11 and `res_sr` equal to the frame SR.
- R6: Format 7 with only `frm_pend[0]` set (trace) gives action 1, `res_fmt` 2 and vector 9. Either floating-point flag overrides trace, and flag 1 overrides flag 2.
- R7: The pending flags have no effect for formats 0, 2, 3 and 4.
- R8: When no format error or redirect applies, an odd PC (bit 0 set) with SR bit 15 (trace) set and SR bit 13 (supervisor) clear gives action 2 (address error), vector 3, `res_fmt` 2, and `res_sr` equal to the frame SR with bit 13 forced to 1.
- R9: In every other case the action is 0 (restore), the vector is 0, `res_fmt` equals the frame format and `res_sr` equals the frame SR.
- R10: For a recognised format, `res_longs` gives the incoming frame size in long words: format 0 gives 2, formats 2 and 3 give 3, format 4 gives 4 and format 7 gives 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame fields are valid this cycle |
| frm_fmt | input | 4 | Format code read from the frame |
| frm_sr | input | 16 | Status register held in the frame |
| frm_pc | input | 32 | Program counter held in the frame |
| frm_pend | input | 3 | Pending flags: bit 0 trace, bit 1 FP post-instruction, bit 2 FP unimplemented |
| res_valid | output | 1 | Result strobe, one cycle after `frm_valid` |
| res_action | output | 2 | 0 restore, 1 redirect, 2 address error, 3 format error |
| res_fmt | output | 4 | Format of the frame to restore or write |
| res_vector | output | 8 | Vector number to fetch (0 on restore) |
| res_sr | output | 16 | SR to reload or to stack |
| res_longs | output | 5 | Long-word transfers of the incoming frame |

## Verification
The bench drives every format code against every combination of pending flags, trace and supervisor bits, and PC parity. This covers the precedence corners. If pending flags leaked into a short-format frame, a restore would turn into a redirect. If trace were preferred over a floating-point flag, the trace vector would appear on a format-7 frame that carries both. If the odd-PC check ran ahead of the redirect, a frame that should become a pending exception would be reported as an address error. A design that copied the SR into the address-error frame without forcing the supervisor bit would show bit 13 clear. A missing hold on idle cycles would change the outputs after the strobe drops.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    localparam int FMT_W   = 4;
    localparam int SR_W    = 16;
    localparam int PC_W    = 32;
    localparam int VEC_W   = 8;
    localparam int LEN_W   = 5;
    localparam int PEND_W  = 3;

    // status register bit positions
    localparam int SR_TRACE_BIT = 15;
    localparam int SR_SUPER_BIT = 13;

    // pending flag positions
    localparam int PEND_TRACE_BIT  = 0;
    localparam int PEND_FPPOST_BIT = 1;
    localparam int PEND_FPUNI_BIT  = 2;

    // frame format codes
    localparam logic [FMT_W-1:0] FMT_SHORT  = 4'd0;
    localparam logic [FMT_W-1:0] FMT_ADDR6  = 4'd2;
    localparam logic [FMT_W-1:0] FMT_EA6    = 4'd3;
    localparam logic [FMT_W-1:0] FMT_EA8    = 4'd4;
    localparam logic [FMT_W-1:0] FMT_ACCESS = 4'd7;

    // vector numbers
    localparam logic [VEC_W-1:0] VEC_NONE     = 8'd0;
    localparam logic [VEC_W-1:0] VEC_ADDR_ERR = 8'd3;
    localparam logic [VEC_W-1:0] VEC_TRACE    = 8'd9;
    localparam logic [VEC_W-1:0] VEC_FP_UNI   = 8'd11;
    localparam logic [VEC_W-1:0] VEC_FMT_ERR  = 8'd14;
    localparam logic [VEC_W-1:0] VEC_FP_POST  = 8'd54;

    typedef enum logic [1:0] {
        ACT_RESTORE  = 2'd0,
        ACT_REDIRECT = 2'd1,
        ACT_ADDR_ERR = 2'd2,
        ACT_FMT_ERR  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        PK_NONE   = 2'd0,
        PK_TRACE  = 2'd1,
        PK_FPPOST = 2'd2,
        PK_FPUNI  = 2'd3
    } pend_kind_e;

    typedef struct packed {
        logic [FMT_W-1:0] fmt;
        logic [SR_W-1:0]  sr;
        logic [PC_W-1:0]  pc;
        logic [PEND_W-1:0] pend;
    } frame_t;

    typedef struct packed {
        act_e             act;
        logic [FMT_W-1:0] fmt;
        logic [VEC_W-1:0] vec;
        logic [SR_W-1:0]  sr;
        logic [LEN_W-1:0] longs;
    } verdict_t;

    // frame size in 16-bit words, 0 when the code is unknown
    function automatic logic [LEN_W:0] frame_words(input logic [FMT_W-1:0] f);
        case (f)
            FMT_SHORT:  frame_words = 6'd4;
            FMT_ADDR6:  frame_words = 6'd6;
            FMT_EA6:    frame_words = 6'd6;
            FMT_EA8:    frame_words = 6'd8;
            FMT_ACCESS: frame_words = 6'd30;
            default:    frame_words = 6'd0;
        endcase
    endfunction

    function automatic logic user_trace(input logic [SR_W-1:0] s);
        return s[SR_TRACE_BIT] && !s[SR_SUPER_BIT];
    endfunction

endpackage

// File: rtl/rfc_format_decode.sv
module rfc_format_decode
    import rfc_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output logic             fmt_known,
    output logic             fmt_access,
    output logic [LEN_W-1:0] longs
);
    logic [LEN_W:0] words;

    always_comb begin
        words      = frame_words(fmt);
        fmt_known  = (words != '0);
        fmt_access = (fmt == FMT_ACCESS);
        // every supported frame is a whole number of long words
        longs      = words[LEN_W:1];
    end
endmodule

// File: rtl/rfc_pending_select.sv
module rfc_pending_select
    import rfc_pkg::*;
(
    input  logic              enable,
    input  logic [PEND_W-1:0] pend,
    output pend_kind_e        kind
);
    always_comb begin
        kind = PK_NONE;
        if (enable) begin
            if (pend[PEND_FPPOST_BIT])
                kind = PK_FPPOST;
            else if (pend[PEND_FPUNI_BIT])
                kind = PK_FPUNI;
            else if (pend[PEND_TRACE_BIT])
                kind = PK_TRACE;
        end
    end
endmodule

// File: rtl/rfc_action_resolve.sv
module rfc_action_resolve
    import rfc_pkg::*;
(
    input  frame_t           frm,
    input  logic             fmt_known,
    input  logic [LEN_W-1:0] longs,
    input  pend_kind_e       kind,
    output verdict_t         vd
);
    logic odd_pc;
    logic forced_sr_s;

    always_comb begin
        odd_pc = frm.pc[0];
        vd.act   = ACT_RESTORE;
        vd.fmt   = frm.fmt;
        vd.vec   = VEC_NONE;
        vd.sr    = frm.sr;
        vd.longs = longs;
        forced_sr_s = 1'b0;

        if (!fmt_known) begin
            vd.act   = ACT_FMT_ERR;
            vd.fmt   = FMT_SHORT;
            vd.vec   = VEC_FMT_ERR;
            vd.longs = '0;
        end else if (kind != PK_NONE) begin
            vd.act = ACT_REDIRECT;
            case (kind)
                PK_FPPOST: begin vd.fmt = FMT_EA6;   vd.vec = VEC_FP_POST; end
                PK_FPUNI:  begin vd.fmt = FMT_ADDR6; vd.vec = VEC_FP_UNI;  end
                default:   begin vd.fmt = FMT_ADDR6; vd.vec = VEC_TRACE;   end
            endcase
        end else if (odd_pc && user_trace(frm.sr)) begin
            vd.act      = ACT_ADDR_ERR;
            vd.fmt      = FMT_ADDR6;
            vd.vec      = VEC_ADDR_ERR;
            forced_sr_s = 1'b1;
        end
        vd.sr[SR_SUPER_BIT] = frm.sr[SR_SUPER_BIT] | forced_sr_s;
    end
endmodule

// File: rtl/rte_frame_check.sv
module rte_frame_check
    import rfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_valid,
    input  logic [FMT_W-1:0]    frm_fmt,
    input  logic [SR_W-1:0]     frm_sr,
    input  logic [PC_W-1:0]     frm_pc,
    input  logic [PEND_W-1:0]   frm_pend,
    output logic                res_valid,
    output logic [1:0]          res_action,
    output logic [FMT_W-1:0]    res_fmt,
    output logic [VEC_W-1:0]    res_vector,
    output logic [SR_W-1:0]     res_sr,
    output logic [LEN_W-1:0]    res_longs
);
    frame_t     frm;
    logic       fmt_known;
    logic       fmt_access;
    logic [LEN_W-1:0] longs;
    pend_kind_e kind;
    verdict_t   vd_next;
    verdict_t   vd_q;
    logic       valid_q;

    assign frm = '{fmt: frm_fmt, sr: frm_sr, pc: frm_pc, pend: frm_pend};

    rfc_format_decode u_dec (
        .fmt        (frm_fmt),
        .fmt_known  (fmt_known),
        .fmt_access (fmt_access),
        .longs      (longs)
    );

    rfc_pending_select u_pend (
        .enable (fmt_access),
        .pend   (frm_pend),
        .kind   (kind)
    );

    rfc_action_resolve u_res (
        .frm       (frm),
        .fmt_known (fmt_known),
        .longs     (longs),
        .kind      (kind),
        .vd        (vd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vd_q    <= '{act: ACT_RESTORE, fmt: '0, vec: '0, sr: '0, longs: '0};
        end else begin
            valid_q <= frm_valid;
            if (frm_valid)
                vd_q <= vd_next;
        end
    end

    assign res_valid  = valid_q;
    assign res_action = vd_q.act;
    assign res_fmt    = vd_q.fmt;
    assign res_vector = vd_q.vec;
    assign res_sr     = vd_q.sr;
    assign res_longs  = vd_q.longs;

    p_strobe_follow_r2: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);
    p_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!res_valid && $stable(res_vector) && $stable(res_sr)));
    p_fmt_err_vec_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_action == ACT_FMT_ERR) |-> (res_vector == VEC_FMT_ERR && res_longs == '0));
    p_redirect_only_access_r7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && kind != PK_NONE) |-> (frm_fmt == FMT_ACCESS));
    p_addr_err_super_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_action == ACT_ADDR_ERR) |-> res_sr[SR_SUPER_BIT]);
    p_restore_sr_r9: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && vd_next.act == ACT_RESTORE) |=> (res_sr == $past(frm_sr) && res_vector == VEC_NONE));
endmodule

// File: tb/sim_rte_frame_check.sv
`timescale 1ns/1ps
module sim_rte_frame_check;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_valid = 1'b0;
    logic [3:0]  frm_fmt = '0;
    logic [15:0] frm_sr = '0;
    logic [31:0] frm_pc = '0;
    logic [2:0]  frm_pend = '0;
    logic        res_valid;
    logic [1:0]  res_action;
    logic [3:0]  res_fmt;
    logic [7:0]  res_vector;
    logic [15:0] res_sr;
    logic [4:0]  res_longs;

    int checks = 0;
    int errors = 0;

    logic [1:0]  e_act;
    logic [3:0]  e_fmt;
    logic [7:0]  e_vec;
    logic [15:0] e_sr;
    logic [4:0]  e_len;
    string       e_tag;

    always #4 clk = ~clk;

    rte_frame_check u0 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_fmt(frm_fmt),
        .frm_sr(frm_sr), .frm_pc(frm_pc), .frm_pend(frm_pend),
        .res_valid(res_valid), .res_action(res_action), .res_fmt(res_fmt),
        .res_vector(res_vector), .res_sr(res_sr), .res_longs(res_longs)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic predict(input logic [3:0] f, input logic [2:0] p,
                           input logic [15:0] s, input logic [31:0] pc);
        int words;
        logic known;
        words = (f == 0) ? 4 : (f == 2 || f == 3) ? 6 : (f == 4) ? 8 : (f == 7) ? 30 : 0;
        known = (words != 0);
        e_len = 5'(words / 2);
        e_sr  = s;
        if (!known) begin
            e_act = 2'd3; e_fmt = 4'd0; e_vec = 8'd14; e_len = 5'd0; e_tag = "R3";
        end else if (f == 7 && p[1]) begin
            e_act = 2'd1; e_fmt = 4'd3; e_vec = 8'd54; e_tag = "R4";
        end else if (f == 7 && p[2]) begin
            e_act = 2'd1; e_fmt = 4'd2; e_vec = 8'd11; e_tag = "R5";
        end else if (f == 7 && p[0]) begin
            e_act = 2'd1; e_fmt = 4'd2; e_vec = 8'd9; e_tag = "R6";
        end else if (pc % 2 == 1 && s[15] == 1'b1 && s[13] == 1'b0) begin
            e_act = 2'd2; e_fmt = 4'd2; e_vec = 8'd3; e_sr = s + 16'h2000; e_tag = "R8";
        end else begin
            e_act = 2'd0; e_fmt = f; e_vec = 8'd0;
            e_tag = (p != 0) ? "R7" : "R9";
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid",  64'(res_valid), 64'd0);
        check("R1 action", 64'(res_action), 64'd0);
        check("R1 vector", 64'(res_vector), 64'd0);
        check("R1 fmt_sr", {res_fmt, res_sr}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {res_valid, res_action, res_vector}, 64'd0);

        for (int f = 0; f < 16; f++) begin
            for (int p = 0; p < 8; p++) begin
                for (int sv = 0; sv < 4; sv++) begin
                    for (int odd = 0; odd < 2; odd++) begin
                        logic [15:0] s;
                        logic [31:0] pc;
                        s  = 16'h0307 | (sv[0] ? 16'h8000 : 16'h0) | (sv[1] ? 16'h2000 : 16'h0);
                        pc = 32'h0001_2340 + 32'(f * 16) + 32'(odd);
                        frm_valid = 1'b1;
                        frm_fmt = 4'(f); frm_pend = 3'(p); frm_sr = s; frm_pc = pc;
                        predict(4'(f), 3'(p), s, pc);
                        @(negedge clk);
                        frm_valid = 1'b0;
                        check("R2 strobe", 64'(res_valid), 64'd1);
                        check({e_tag, " verdict"}, {res_action, res_fmt, res_vector, res_sr},
                              {e_act, e_fmt, e_vec, e_sr});
                        check("R10 longs", 64'(res_longs), 64'(e_len));
                    end
                end
            end
        end

        // R2: idle cycle with changed inputs keeps last result
        frm_valid = 1'b0;
        frm_fmt = 4'd7; frm_pend = 3'b010; frm_sr = 16'hFFFF; frm_pc = 32'h1;
        @(negedge clk);
        check("R2 idle valid", 64'(res_valid), 64'd0);
        check("R2 idle hold", {res_action, res_fmt, res_vector, res_sr, res_longs},
              {e_act, e_fmt, e_vec, e_sr, e_len});

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule